// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects hardware event pulses into a sticky status register and drives one level-sensitive interrupt line toward an interrupt controller. The line is high while any status bit is set whose mask bit is clear. Software reaches the block through a 32-bit register port with four word locations: status, mask, unmask and domask.

The mask cannot be written in place. Software clears mask bits by writing ones to the unmask location, and sets them by writing ones to the domask location. Neither location stores anything, and both read as zero. Status bits are cleared by writing a one to them. A hardware event arriving in the same cycle as a software clear wins, so no event is lost.

A two-state line machine follows the pending condition. In state QUIET the line is low. The RAISE transition goes to RAISED when pending is true. The DROP transition goes back to QUIET when pending is false. Any other case holds the state. Because the line is registered, it follows a register change by one cycle.

Top module: `isr_mask_ctrl`

## Requirements
- R1: While reset is held, and after it is released, status is all zero, every implemented mask bit is one (0x1 with one source), `irq_out` is low and `bus_rvalid` is low.
- R2: Word index 0 selects status, 1 selects mask, 2 selects unmask and 3 selects domask. An accepted read returns its data on `bus_rdata` with `bus_rvalid` high, exactly one cycle after the request cycle.
- R3: A high `hw_event` bit sets the matching status bit on the next edge. If a status write with a one in that bit lands in the same cycle, the bit still ends up set.
- R4: Writing status clears every bit written as 1. Bits written as 0 keep their value.
- R5: A write to the mask location changes no mask bit.
- R6: A write to unmask clears every mask bit written as 1 and leaves the other mask bits alone.
- R7: A write to domask sets every mask bit written as 1 and leaves the other mask bits alone.
- R8: Reads of unmask and domask return zero.
- R9: `irq_out` is high exactly when some status bit is 1 while its mask bit is 0, sampled one cycle earlier. The line rises one cycle after the register change that makes the condition true, and falls one cycle after the change that makes it false.
- R10: A request with `bus_full_word` low is ignored. It changes no register and produces no `bus_rvalid`.
- R11: Status and mask bits at or above `NSRC` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index of the register |
| bus_full_word | input | 1 | 1 when the access is a full 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after an accepted read |
| hw_event | input | NSRC | Event pulses, one per status bit |
| irq_out | output | 1 | Level interrupt line |

## Verification
The bench builds the block with `NSRC` = 1, which is the default. In this shape, a write of all ones to any location also sweeps the 31 unimplemented bit positions. That makes the zero read-back of unused bits, and the refusal of the mask to change, visible through ordinary reads. With a single source, each line transition can be tied to exactly one status or mask change. This lets the bench check set-versus-clear priority, the one-cycle line latency and the partial-width rejection against fixed expected values.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_UNMASK = 2'd2,
        REG_DOMASK = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/isr_status_bank.sv
module isr_status_bank #(
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_en,
    input  logic [NSRC-1:0] clr_bits,
    input  logic [NSRC-1:0] set_bits,
    output logic [NSRC-1:0] stat_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic nxt;
        always_comb begin
            nxt = stat_q[i];
            if (clr_en && clr_bits[i]) nxt = 1'b0;
            if (set_bits[i])           nxt = 1'b1;  // set wins
        end
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= nxt;
        end
    end

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_bits[0] |=> stat_q[0]);
    a_r4_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_bits[0] && !set_bits[0]) |=> !stat_q[0]);
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !clr_bits[0] && stat_q[0]) |=> stat_q[0]);
endmodule

// File: rtl/isr_mask_bank.sv
module isr_mask_bank #(
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            unmask_en,
    input  logic            domask_en,
    input  logic [NSRC-1:0] bits,
    output logic [NSRC-1:0] mask_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic nxt;
        always_comb begin
            nxt = mask_q[i];
            if (unmask_en && bits[i]) nxt = 1'b0;
            if (domask_en && bits[i]) nxt = 1'b1;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) mask_q[i] <= 1'b1;
            else        mask_q[i] <= nxt;
        end
    end

    a_r6_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (unmask_en && bits[0]) |=> !mask_q[0]);
    a_r7_domask_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (domask_en && bits[0]) |=> mask_q[0]);
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmask_en && !domask_en) |=> $stable(mask_q));
endmodule

// File: rtl/isr_line_fsm.sv
module isr_line_fsm
    import isr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    line_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending)  state_d = LINE_RAISED;  // RAISE
            LINE_RAISED: if (!pending) state_d = LINE_QUIET;   // DROP
            default:                   state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LINE_RAISED: irq = 1'b1;
            default:     irq = 1'b0;
        endcase
    end

    a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq);
    a_r9_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq);
endmodule

// File: rtl/isr_mask_ctrl.sv
module isr_mask_ctrl
    import isr_pkg::*;
#(
    parameter int NSRC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_full_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NSRC-1:0]   hw_event,
    output logic              irq_out
);
    reg_sel_e          sel;
    logic              acc_ok, wr_ok, rd_ok;
    logic [NSRC-1:0]   stat_q, mask_q;
    logic [DATA_W-1:0] stat_rd, mask_rd, rd_mux;
    logic              pending;

    assign sel    = reg_sel_e'(bus_addr);
    assign acc_ok = bus_sel && bus_full_word;
    assign wr_ok  = acc_ok && bus_wr;
    assign rd_ok  = acc_ok && !bus_wr;

    isr_status_bank #(.NSRC(NSRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (wr_ok && sel == REG_STATUS),
        .clr_bits (bus_wdata[NSRC-1:0]),
        .set_bits (hw_event),
        .stat_q   (stat_q)
    );

    isr_mask_bank #(.NSRC(NSRC)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .unmask_en (wr_ok && sel == REG_UNMASK),
        .domask_en (wr_ok && sel == REG_DOMASK),
        .bits      (bus_wdata[NSRC-1:0]),
        .mask_q    (mask_q)
    );

    assign pending = |(stat_q & ~mask_q);

    isr_line_fsm u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .irq     (irq_out)
    );

    always_comb begin
        stat_rd = '0;
        mask_rd = '0;
        stat_rd[NSRC-1:0] = stat_q;
        mask_rd[NSRC-1:0] = mask_q;
    end

    always_comb begin
        unique case (sel)
            REG_STATUS: rd_mux = stat_rd;
            REG_MASK:   rd_mux = mask_rd;
            default:    rd_mux = '0;  // unmask / domask store nothing
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_ok;
            if (rd_ok) bus_rdata <= rd_mux;
        end
    end

    a_r10_partial_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_full_word) |=> !bus_rvalid);
    a_r2_strobe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |=> bus_rvalid);
    a_r8_companions_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && (sel == REG_UNMASK || sel == REG_DOMASK)) |=> bus_rdata == '0);
    a_r5_mask_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel == REG_MASK) |=> $stable(mask_q));

    if (NSRC < DATA_W) begin : g_unused_chk
        a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rvalid |-> bus_rdata[DATA_W-1:NSRC] == '0);
    end
endmodule

// File: tb/sim_isr_mask_ctrl.sv
module sim_isr_mask_ctrl;
    localparam int NV = 27;
    localparam logic [1:0] OP_NONE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
    localparam logic [1:0] A_ST = 2'd0, A_MK = 2'd1, A_UN = 2'd2, A_DM = 2'd3;

    // {op, addr, wdata, event, expected rdata, expected irq}
    localparam logic [69:0] VEC [0:NV-1] = '{
        {OP_RD,   A_MK, 32'h0,        1'b0, 32'h1, 1'b0},  // R1 R2 mask resets to 1
        {OP_NONE, A_ST, 32'h0,        1'b1, 32'h0, 1'b0},  // R3 event, still masked
        {OP_RD,   A_ST, 32'h0,        1'b0, 32'h1, 1'b0},  // R3
        {OP_WR,   A_UN, 32'h1,        1'b0, 32'h0, 1'b1},  // R6 R9
        {OP_RD,   A_MK, 32'h0,        1'b0, 32'h0, 1'b1},  // R6
        {OP_RD,   A_UN, 32'h0,        1'b0, 32'h0, 1'b1},  // R8
        {OP_WR,   A_MK, 32'h1,        1'b0, 32'h0, 1'b1},  // R5
        {OP_RD,   A_MK, 32'h0,        1'b0, 32'h0, 1'b1},  // R5
        {OP_WR,   A_ST, 32'h0,        1'b0, 32'h0, 1'b1},  // R4 zero no effect
        {OP_RD,   A_ST, 32'h0,        1'b0, 32'h1, 1'b1},  // R4
        {OP_WR,   A_DM, 32'h1,        1'b0, 32'h0, 1'b0},  // R7 R9
        {OP_RD,   A_DM, 32'h0,        1'b0, 32'h0, 1'b0},  // R8
        {OP_RD,   A_MK, 32'h0,        1'b0, 32'h1, 1'b0},  // R7
        {OP_WR,   A_UN, 32'hFFFFFFFF, 1'b0, 32'h0, 1'b1},  // R6
        {OP_WR,   A_ST, 32'hFFFFFFFF, 1'b0, 32'h0, 1'b0},  // R4
        {OP_RD,   A_ST, 32'h0,        1'b0, 32'h0, 1'b0},  // R4
        {OP_WR,   A_DM, 32'hFFFFFFFE, 1'b0, 32'h0, 1'b0},  // R7 bit0 zero
        {OP_RD,   A_MK, 32'h0,        1'b0, 32'h0, 1'b0},  // R7 R11
        {OP_NONE, A_ST, 32'h0,        1'b1, 32'h0, 1'b1},  // R3 R9
        {OP_RD,   A_ST, 32'h0,        1'b0, 32'h1, 1'b1},  // R3
        {OP_WR,   A_DM, 32'hFFFFFFFF, 1'b0, 32'h0, 1'b0},  // R7
        {OP_RD,   A_MK, 32'h0,        1'b0, 32'h1, 1'b0},  // R11
        {OP_WR,   A_ST, 32'h1,        1'b0, 32'h0, 1'b0},  // R4
        {OP_RD,   A_ST, 32'h0,        1'b0, 32'h0, 1'b0},  // R4
        {OP_WR,   A_ST, 32'h1,        1'b1, 32'h0, 1'b0},  // R3 set beats clear
        {OP_RD,   A_ST, 32'h0,        1'b0, 32'h1, 1'b0},  // R3
        {OP_WR,   A_UN, 32'h1,        1'b0, 32'h0, 1'b1}   // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_full_word = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [0:0]  hw_event = '0;
    logic        irq_out;
    int          checks = 0, errors = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    isr_mask_ctrl #(.NSRC(1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_full_word(bus_full_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .hw_event(hw_event), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [1:0] a, input logic [31:0] d,
                         input logic ev, input logic full,
                         output logic [31:0] rd, output logic rv, output logic irq);
        @(negedge clk);
        bus_sel = (op != OP_NONE);
        bus_wr = (op == OP_WR);
        bus_addr = a;
        bus_wdata = d;
        hw_event = ev;
        bus_full_word = full;
        @(posedge clk);
        @(negedge clk);
        rd = bus_rdata;
        rv = bus_rvalid;
        bus_sel = 1'b0;
        hw_event = '0;
        bus_full_word = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq = irq_out;
    endtask

    initial begin
        logic [31:0] rd;
        logic rv, irq;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq in reset", {31'b0, irq_out}, 32'h0);
        chk("R1 rvalid in reset", {31'b0, bus_rvalid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after release", {31'b0, irq_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [69:0] v;
            v = VEC[i];
            do_op(v[69:68], v[67:66], v[65:34], v[33], 1'b1, rd, rv, irq);
            chk($sformatf("R2 rvalid vec %0d", i), {31'b0, rv}, {31'b0, v[69:68] == OP_RD});
            if (v[69:68] == OP_RD)
                chk($sformatf("R2 rdata vec %0d", i), rd, v[32:1]);
            chk($sformatf("R9 irq vec %0d", i), {31'b0, irq}, {31'b0, v[0]});
        end

        // R10: partial-width write to status must not clear it
        do_op(OP_WR, A_ST, 32'h1, 1'b0, 1'b0, rd, rv, irq);
        chk("R10 partial write rvalid", {31'b0, rv}, 32'h0);
        chk("R10 partial write irq kept", {31'b0, irq}, 32'h1);
        do_op(OP_RD, A_ST, 32'h0, 1'b0, 1'b0, rd, rv, irq);
        chk("R10 partial read no rvalid", {31'b0, rv}, 32'h0);
        do_op(OP_WR, A_DM, 32'h1, 1'b0, 1'b0, rd, rv, irq);
        chk("R10 partial domask ignored", {31'b0, irq}, 32'h1);
        do_op(OP_RD, A_ST, 32'h0, 1'b0, 1'b1, rd, rv, irq);
        chk("R10 status still set", rd, 32'h1);

        // R1: reset mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 irq low in reset", {31'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        do_op(OP_RD, A_MK, 32'h0, 1'b0, 1'b1, rd, rv, irq);
        chk("R1 mask after reset", rd, 32'h1);
        do_op(OP_RD, A_ST, 32'h0, 1'b0, 1'b1, rd, rv, irq);
        chk("R1 status after reset", rd, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        done = 1'b1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule